// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is an SPI bus master that a processor drives through five 32-bit registers: a mode register, two setup registers, a status register and a data port. Software puts the block into its setup mode, programs clock polarity, clock phase, bit order, word length (8 or 16 bits) and the SCK divider, then switches to the run mode and writes words into the data port. Each word written goes into a four-entry transmit queue. Every word shifted out brings one word in from MISO, and that word goes into a four-entry receive queue. Software drains the receive queue by reading the data port.

A receive fill-level threshold can raise an interrupt once enough words have arrived, so software can send a batch of up to four words and sleep until the answers are in. A clear command empties both queues and aborts any word in progress. A hold bit stops new words from starting. Chip selects are not part of the block.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the mode register reads 0x40 (setup mode) and setup register 0 reads 0. Setup register 1 reads 0x0108 (divider 1, 8-bit words). Status reads 0x0004, irq is 0, SCK is 0, and a data read returns 0.
- R2: Register offsets are 0x00 mode, 0x04 setup 0, 0x08 setup 1, 0x14 status and 0x18 data. Setup 0 holds polarity in bit 0, phase in bit 1, MSB-first in bit 2, the receive interrupt enable in bit 9 and the threshold (words-1) in bits [13:12]. Setup 1 holds the divider in bits [15:8], where a write of 0 is stored as 1. A write with bit 4 set selects 16-bit words, and the length field reads back as 16 or 8.
- R3: Writes to setup 1 and to setup 0 bits [2:0] take effect only while the mode field (bits [7:6]) is 01. At other times those fields keep their value, while the threshold and interrupt enable stay writable.
- R4: A queued word starts shifting only when the mode field is 10 and the hold bit (mode bit 1) is clear. Otherwise it waits in the transmit queue.
- R5: With divider n, one SCK period lasts n+1 clock cycles. The first half of each bit lasts floor((n+1)/2) cycles.
- R6: SCK rests at the polarity bit. With phase 0, each bit is presented before the leading edge and sampled on it. With phase 1, each bit changes on the leading edge and is sampled on the trailing edge.
- R7: With MSB-first set, bit 15 (16-bit mode) or bit 7 (8-bit mode) goes out first. With it clear, bit 0 goes out first. Received bits are assembled in the same order.
- R8: In 8-bit mode only data bits [7:0] are sent, over 8 SCK periods, and received words read back zero-extended. In 16-bit mode all 16 bits are sent.
- R9: Each transmitted word yields exactly one received word. Data reads return received words in arrival order, and a read of an empty receive queue returns 0.
- R10: The transmit queue holds four words. A data write while it is full is dropped and sets status bit 7, which stays set until a clear.
- R11: Writing 1 to mode bit 0 empties both queues, clears status bit 7 and aborts the word in progress, returning SCK to rest.
- R12: Status bit 14 is set while the receive count is at least threshold+1. Bits [13:11] give the transmit count and bits [10:8] the receive count. Bit 2 is set when no word is shifting or completing and the transmit queue is empty.
- R13: irq follows (setup 0 bit 9 AND status bit 14) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive threshold interrupt |

## Verification
The bench loops MOSI back inverted onto MISO. For all four clock modes, both bit orders and both word lengths, it rebuilds each shifted word from MOSI on the edge where the slave would sample. A design that samples on the wrong edge or reverses the order produces a skewed or mirrored word, and a wrong divider shows up as a wrong edge spacing. Further checks cover a fifth write to a full queue, which a faulty design would store or fail to flag as sticky, and a threshold that fires one word early or late. Other checks write to setup registers in run mode, which a faulty design would accept, and issue a clear in the middle of a word, which a faulty design would finish and push into the receive queue.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int OFF_MODE  = 'h00;
  localparam int OFF_SET0  = 'h04;
  localparam int OFF_SET1  = 'h08;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_DATA  = 'h18;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CFG = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } spim_mode_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> count == $past(count));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              wide,
  input  logic              msb_first,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int HALF_W = WORD_W / 2;

  logic [DIV_W:0]      period, lead, trail, cnt;
  logic                half;
  logic [BIT_W-1:0]    bitn, topi;
  logic [WORD_W-1:0]   sr, rsr, rsr_smp, mask;

  assign period = {1'b0, div} + (DIV_W + 1)'(1);
  assign lead   = period >> 1;
  assign trail  = period - lead;
  assign topi   = wide ? BIT_W'(WORD_W - 1) : BIT_W'(HALF_W - 1);
  assign mask   = wide ? '1 : {{(WORD_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};

  always_comb begin
    if (msb_first) begin
      rsr_smp = {rsr[WORD_W-2:0], miso};
    end else begin
      rsr_smp = rsr >> 1;
      rsr_smp[topi] = miso;
    end
  end

  assign mosi = msb_first ? sr[topi] : sr[0];
  assign sck  = busy ? (cpol ^ (cpha ? ~half : half)) : cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      half    <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      sr      <= '0;
      rsr     <= '0;
      rx_word <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      done <= 1'b0;
      half <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          half <= 1'b0;
          cnt  <= lead - (DIV_W + 1)'(1);
          bitn <= '0;
          sr   <= tx_word & mask;
          rsr  <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - (DIV_W + 1)'(1);
      end else if (!half) begin
        rsr  <= rsr_smp;
        half <= 1'b1;
        cnt  <= trail - (DIV_W + 1)'(1);
      end else if (bitn == topi) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        half    <= 1'b0;
        rx_word <= rsr & mask;
      end else begin
        bitn <= bitn + BIT_W'(1);
        half <= 1'b0;
        cnt  <= lead - (DIV_W + 1)'(1);
        sr   <= msb_first ? (sr << 1) : (sr >> 1);
      end
    end
  end

  // R6: between words SCK rests at the polarity level
  a_r6_sck_rest: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(cpol)) |-> $stable(sck));
  // R9: a completed word is reported exactly once
  a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int ADDR_W     = 5,
  parameter int WORD_W     = 16,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  import spim_pkg::*;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  spim_mode_e        mode_q;
  logic              hold_q, cpol_q, cpha_q, msb_q, rx_ie_q, wide_q, ovr_q, irq_q;
  logic [1:0]        lvl_q;
  logic [DIV_W-1:0]  div_q, div_in;
  logic [31:0]       rdata_q, stat;

  logic wr_mode, wr_set0, wr_set1, wr_data, rd_data, cfg_ok, clr;
  logic tx_full, tx_empty, rx_full, rx_empty, busy, done, start, thr;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;

  assign wr_mode = bus_wr && (bus_addr == ADDR_W'(OFF_MODE));
  assign wr_set0 = bus_wr && (bus_addr == ADDR_W'(OFF_SET0));
  assign wr_set1 = bus_wr && (bus_addr == ADDR_W'(OFF_SET1));
  assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));
  assign cfg_ok  = (mode_q == MODE_CFG);
  assign clr     = wr_mode && bus_wdata[0];
  assign div_in  = bus_wdata[8 +: DIV_W];
  assign start   = (mode_q == MODE_RUN) && !hold_q && !busy && !tx_empty && !rx_full;
  assign thr     = rx_cnt >= (CNT_W'(lvl_q) + CNT_W'(1));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .clr(clr),
    .push(wr_data), .wdata(bus_wdata[WORD_W-1:0]),
    .pop(start), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .clr(clr),
    .push(done), .wdata(rx_word),
    .pop(rd_data), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.WORD_W(WORD_W), .DIV_W(DIV_W)) shift_i (
    .clk(clk), .rst(rst), .abort(clr), .start(start), .tx_word(tx_head),
    .wide(wide_q), .msb_first(msb_q), .cpol(cpol_q), .cpha(cpha_q),
    .div(div_q), .miso(miso), .busy(busy), .done(done),
    .rx_word(rx_word), .sck(sck), .mosi(mosi));

  always_comb begin
    stat        = '0;
    stat[14]    = thr;
    stat[13:11] = 3'(tx_cnt);
    stat[10:8]  = 3'(rx_cnt);
    stat[7]     = ovr_q;
    stat[2]     = !busy && !done && tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_CFG;
      hold_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      msb_q   <= 1'b0;
      rx_ie_q <= 1'b0;
      lvl_q   <= '0;
      div_q   <= DIV_W'(1);
      wide_q  <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_mode) begin
        mode_q <= spim_mode_e'(bus_wdata[7:6]);
        hold_q <= bus_wdata[1];
      end
      if (wr_set0) begin
        lvl_q   <= bus_wdata[13:12];
        rx_ie_q <= bus_wdata[9];
        if (cfg_ok) begin
          msb_q  <= bus_wdata[2];
          cpha_q <= bus_wdata[1];
          cpol_q <= bus_wdata[0];
        end
      end
      if (wr_set1 && cfg_ok) begin
        div_q  <= (div_in == '0) ? DIV_W'(1) : div_in;
        wide_q <= bus_wdata[4];
      end
      if (clr)                    ovr_q <= 1'b0;
      else if (wr_data && tx_full) ovr_q <= 1'b1;
      irq_q <= rx_ie_q && thr;
      if (bus_rd) begin
        case (int'(bus_addr))
          OFF_MODE: rdata_q <= {24'b0, mode_q, 4'b0, hold_q, 1'b0};
          OFF_SET0: rdata_q <= {18'b0, lvl_q, 2'b0, rx_ie_q, 6'b0, msb_q, cpha_q, cpol_q};
          OFF_SET1: rdata_q <= 32'({div_q, 3'b0, wide_q ? 5'd16 : 5'd8});
          OFF_STAT: rdata_q <= stat;
          OFF_DATA: rdata_q <= rx_empty ? '0 : 32'(rx_head);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  a_r3_setup_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_CFG) |=> $stable({div_q, wide_q, cpol_q, cpha_q, msb_q}));
  a_r4_start_in_run: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(mode_q == MODE_RUN && !hold_q));
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !clr) |=> ovr_q);
  a_r13_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_ie_q));
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tx_cnt == '0 && rx_cnt == '0 && !busy));
endmodule

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb_top;
  localparam int A_MODE = 'h00, A_SET0 = 'h04, A_SET1 = 'h08, A_STAT = 'h14, A_DATA = 'h18;
  // {cpol[27], cpha[26], msb[25], wide[24], div[23:16], word[15:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h020112C5, 32'h0702BEEF, 32'h08030031, 32'h0D068001,
    32'h01041234, 32'h0E0900F0, 32'h04FF0096, 32'h0B017E81};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso, irq;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = ~mosi;

  spi_regmaster dut_i (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq));

  // slave-side capture of MOSI at the sampling edge
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, prev_sck = 1'b0, lead_seen = 1'b0;
  logic [31:0] cap = '0;
  int ncap = 0, last_lead = 0, per = 0;
  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      if ((sck != cfg_cpol) != cfg_cpha) begin
        cap = {cap[30:0], mosi};
        ncap++;
      end
      if (sck != cfg_cpol) begin
        if (lead_seen) per = cyc - last_lead;
        last_lead = cyc;
        lead_seen = 1'b1;
      end
    end
    prev_sck = sck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, s);
      if (s[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic [31:0] d, expbits;
    logic [15:0] w, m;
    int bits;
    w = v[15:0];
    bits = v[24] ? 16 : 8;
    m = v[24] ? 16'hFFFF : 16'h00FF;
    wr(A_MODE, 32'h41);
    wr(A_SET0, {29'b0, v[25], v[26], v[27]});
    wr(A_SET1, {16'b0, v[23:16], v[24] ? 8'd16 : 8'd8});
    cfg_cpol = v[27]; cfg_cpha = v[26];
    wr(A_MODE, 32'h80);
    @(negedge clk); #1;
    cap = '0; ncap = 0; per = 0; lead_seen = 1'b0;
    wr(A_DATA, {16'hC3C3, w});
    wait_idle();
    expbits = '0;
    for (int i = 0; i < bits; i++)
      expbits = {expbits[30:0], v[25] ? w[bits-1-i] : w[i]};
    chk("R7 bit order/R6 sampling edge", cap & 32'(m), expbits);
    chk("R8 SCK periods per word", 32'(ncap), 32'(bits));
    chk("R5 SCK period", 32'(per), 32'(v[23:16]) + 1);
    chk("R6 SCK rest level", {31'b0, sck}, {31'b0, v[27]});
    rd(A_DATA, d);
    chk("R9 received word", d, {16'b0, ~w & m});
    rd(A_DATA, d);
    chk("R9 empty read", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_MODE, d); chk("R1 mode reset", d, 32'h40);
    rd(A_SET0, d); chk("R1 setup0 reset", d, 32'h0);
    rd(A_SET1, d); chk("R1 setup1 reset", d, 32'h0108);
    rd(A_STAT, d); chk("R1 status reset", d, 32'h0004);
    chk("R1 irq/sck reset", {30'b0, irq, sck}, 32'h0);
    rd(A_DATA, d); chk("R1 empty data", d, 32'h0);

    // table-driven transfers over modes, orders, widths, dividers
    foreach (VEC[i]) run_vec(VEC[i]);

    // R2 field layout and divider clamp
    wr(A_MODE, 32'h41);
    wr(A_SET1, 32'h0010);
    rd(A_SET1, d); chk("R2 divider zero clamps, 16-bit", d, 32'h0110);
    wr(A_SET0, 32'h3207);
    rd(A_SET0, d); chk("R2 setup0 readback", d, 32'h3207);
    // R3 writes gated outside setup mode
    wr(A_MODE, 32'h80);
    wr(A_SET1, 32'h0508);
    rd(A_SET1, d); chk("R3 setup1 frozen", d, 32'h0110);
    wr(A_SET0, 32'h2000);
    rd(A_SET0, d); chk("R3 setup0 partial", d, 32'h2007);

    // R4 start gating by mode and hold
    wr(A_MODE, 32'h41);
    wr(A_SET0, 32'h0004);
    wr(A_SET1, 32'h0108);
    wr(A_DATA, 32'h5A);
    repeat (20) @(negedge clk);
    rd(A_STAT, d); chk("R4 waits in setup mode", d, 32'h0800);
    wr(A_MODE, 32'h82);
    repeat (40) @(negedge clk);
    rd(A_STAT, d); chk("R4 waits on hold", d, 32'h0800);
    wr(A_MODE, 32'h80);
    wait_idle();
    rd(A_STAT, d); chk("R12 status after one word", d, 32'h4104);
    rd(A_DATA, d); chk("R9 word after hold", d, 32'hA5);

    // R10/R12/R13 full queue, threshold and interrupt
    wr(A_MODE, 32'h41);
    wr(A_SET0, 32'h1204);
    wr(A_SET1, 32'h0108);
    wr(A_DATA, 32'h11); wr(A_DATA, 32'h22); wr(A_DATA, 32'h33);
    wr(A_DATA, 32'h44); wr(A_DATA, 32'h55);
    rd(A_STAT, d); chk("R10 full queue and overrun", d, 32'h2080);
    chk("R13 irq low before data", {31'b0, irq}, 32'h0);
    wr(A_MODE, 32'h80);
    wait_idle();
    rd(A_STAT, d); chk("R12 four words received", d, 32'h4484);
    chk("R13 irq at threshold", {31'b0, irq}, 32'h1);
    rd(A_DATA, d); chk("R9 order 1", d, 32'hEE);
    rd(A_DATA, d); chk("R9 order 2", d, 32'hDD);
    @(negedge clk);
    chk("R13 irq with two words", {31'b0, irq}, 32'h1);
    rd(A_DATA, d); chk("R9 order 3", d, 32'hCC);
    repeat (2) @(negedge clk);
    chk("R13 irq below threshold", {31'b0, irq}, 32'h0);
    rd(A_DATA, d); chk("R9 order 4", d, 32'hBB);
    rd(A_DATA, d); chk("R10 dropped fifth word", d, 32'h0);
    rd(A_STAT, d); chk("R10 overrun sticky", d, 32'h0084);
    wr(A_MODE, 32'h81);
    rd(A_STAT, d); chk("R11 clear drops overrun", d, 32'h0004);

    // R11 abort mid-word
    wr(A_MODE, 32'h41);
    wr(A_SET0, 32'h0004);
    wr(A_SET1, 32'hFF10);
    cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    wr(A_MODE, 32'h80);
    wr(A_DATA, 32'hFFFF);
    wr(A_DATA, 32'h1234);
    repeat (200) @(negedge clk);
    rd(A_STAT, d); chk("R4 word in flight", d, 32'h0800);
    wr(A_MODE, 32'h81);
    repeat (5000) @(negedge clk);
    rd(A_STAT, d); chk("R11 abort leaves queues empty", d, 32'h0004);
    chk("R11 SCK at rest", {31'b0, sck}, 32'h0);
    rd(A_DATA, d); chk("R11 no word received", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule